// File: doc/BRIEF.md
# Three-Wire Nibble Register Slave

This block is the device side of a three-wire serial link: a chip-enable input, a shift-clock input and one shared data line. It holds sixteen 4-bit registers that the host reaches through that link. The block runs on a system clock and oversamples the serial pins. A transfer begins on a rising edge of enable. While enable stays high, the host sends 8-clock frames, most significant bit first, and the block samples each bit on the falling edge of the shift clock.

Each frame starts with a 4-bit control field. The block ignores the first bit of that field. The next three bits are read/write (RW), address-strobe (AD) and data-strobe (DT). The last four bits of the frame are either an address or a data nibble. A read frame is followed by an 8-clock output group: the block takes the data line at the second rising edge of that group and shifts the nibble out on the last four rising edges. It releases the line at the first rising edge of the group that follows. Further frames can come while enable is still high. Taking enable low aborts whatever is in progress.

The data line is split into input, output and output-enable signals, so the pad driver sits outside the block.

Top module: `nib3w_slave`

## Requirements
- R1: After reset, `sdio_oe` is 0 and all sixteen registers read back as 0.
- R2: While enable is low, `sdio_oe` is 0. A frame cut short by enable going low writes no register, and the next transfer restarts bit counting from the first control bit.
- R3: Frame bits are sampled on falling shift-clock edges, MSB first. Frame bit 7 is ignored, so frames that differ only in bit 7 act identically.
- R4: The address register loads frame bits 3..0 only when AD (bit 5) is 1 and DT (bit 4) is 0. No other control value changes it.
- R5: A register is written only when RW (bit 6) is 0, AD is 0 and DT is 1. Frame bits 3..0 are then stored at the current address. Every other control value writes nothing.
- R6: After a read frame (RW=1, AD=1, DT=0), `sdio_oe` stays 0 through the first rising edge of the next 8-clock group and goes to 1 at its second rising edge.
- R7: In the output group, `sdio_o` carries read bits 3, 2, 1 and 0 from the rising edges 5, 6, 7 and 8. Each bit holds until the next rising edge. The value read is the register at the address in the read frame.
- R8: `sdio_oe` returns to 0 at the first rising edge after the output group. The falling edge of that same clock pulse is the first bit of a new frame, under the same enable.
- R9: Enable that is already high when reset ends starts no transfer. Frames sent before a low-to-high transition of enable have no effect.
- R10: A data write changes exactly one register, the one that the address register selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial chip enable, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| sdio_i | input | 1 | Data line input from the pad |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |

## Verification
The hardest cases to reach are the ones where enable falls at an awkward point: partway through a write frame, or after the block has already started driving the line for a read. The stimulus cuts a write frame after five bits and then reads the target address in a fresh transfer. It also starts a read, confirms the line is driven at the second output clock, and drops enable to check that the line is released. A second hard case is a frame that follows a read without enable going low. For this, reads are chained back to back and a write frame is sent straight after an output group, with a check that the line has turned around at the shared clock pulse.

// File: rtl/nib3w_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and frame-layout constants for the three-wire slave.
// Assumes a fixed 4-bit control field at the head of every frame.
package nib3w_pkg;

    localparam int CTRL_W = 4;   // control field width, first bit ignored

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,         // waiting for an enable rising edge
        LNK_CMD   = 2'd1,         // shifting in a control/payload frame
        LNK_RDOUT = 2'd2,         // read output group in progress
        LNK_TAIL  = 2'd3          // waiting for the edge that releases the line
    } link_state_t;

endpackage

// File: rtl/nib3w_sync.sv
`timescale 1ns/1ps
// Module: two-stage synchronizer bank for W asynchronous inputs.
// Assumes the inputs are slow compared with clk. RST_VAL gives the settled
// value that each bit takes in reset.
module nib3w_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic meta_q;
            logic safe_q;

            // Purpose: two flops in series bring this bit into the clk domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[b];
                    safe_q <= RST_VAL[b];
                end else begin
                    meta_q <= async_i[b];
                    safe_q <= meta_q;
                end
            end

            assign level_o[b] = safe_q;
        end
    endgenerate

endmodule

// File: rtl/nib3w_edge.sv
`timescale 1ns/1ps
// Module: single-cycle rise and fall pulses for one synchronized level.
// Assumes the input is already in the clk domain. RST_VAL stops a level that
// is steady from reset from producing a spurious edge.
module nib3w_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    // Purpose: keep the previous sample so that edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/nib3w_regfile.sv
`timescale 1ns/1ps
// Module: 2**NIB_W cells of NIB_W bits with one write port and a combinational
// read port. Assumes the caller gives at most one write strobe per cycle.
// The decoded per-cell write hits are brought out so they can be checked.
module nib3w_regfile #(
    parameter int NIB_W = 4,
    localparam int DEPTH = 2 ** NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic [NIB_W-1:0] wr_idx_i,
    input  logic [NIB_W-1:0] wr_data_i,
    input  logic [NIB_W-1:0] rd_idx_i,
    output logic [NIB_W-1:0] rd_data_o,
    output logic [DEPTH-1:0] wr_hit_o
);

    logic [NIB_W-1:0] cells [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            logic [NIB_W-1:0] cell_q;

            assign wr_hit_o[i] = wr_stb_i && (wr_idx_i == NIB_W'(i));

            // Purpose: store a data nibble when this cell is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)           cell_q <= '0;
                else if (wr_hit_o[i]) cell_q <= wr_data_i;
            end

            assign cells[i] = cell_q;
        end
    endgenerate

    assign rd_data_o = cells[rd_idx_i];

endmodule

// File: rtl/nib3w_frame.sv
`timescale 1ns/1ps
// Module: frame engine. It counts shift-clock edges, decodes the control
// field, holds the address register, issues write strobes and sequences the
// read output group on the data line.
// Assumes enable and clock edges arrive as single-cycle pulses from the sync
// logic, and that din is delayed by the same amount as the clock.
module nib3w_frame
    import nib3w_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int FRAME_W = CTRL_W + NIB_W,
    localparam int LAST    = FRAME_W - 1,
    localparam int CNT_W   = $clog2(FRAME_W),
    localparam int BSEL_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1,
    localparam int SH_W    = FRAME_W - 2,
    localparam int DRIVE_K = 1,                 // rising edge 2 of the group
    localparam int DATA_K  = FRAME_W - NIB_W    // rising edge where data starts
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_lvl_i,
    input  logic             en_rise_i,
    input  logic             sck_rise_i,
    input  logic             sck_fall_i,
    input  logic             din_i,
    input  logic [NIB_W-1:0] rd_nib_i,
    output logic [NIB_W-1:0] rd_idx_o,
    output logic [NIB_W-1:0] addr_o,
    output logic             wr_stb_o,
    output logic [NIB_W-1:0] wr_data_o,
    output logic             dout_o,
    output logic             doe_o
);

    link_state_t       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SH_W-1:0]   shift_q;     // the ignored first bit drops off the top
    logic [NIB_W-1:0]  addr_q;
    logic [NIB_W-1:0]  rd_hold_q;
    logic [NIB_W-1:0]  payload;
    logic              ctl_rw, ctl_ad, ctl_dt;
    logic              frame_end, is_addr, is_write, is_read;
    logic              cnt_last;
    logic [BSEL_W-1:0] bit_sel;

    // Purpose: decode the frame as it would be complete if this bit ends it.
    always_comb begin
        ctl_rw    = shift_q[SH_W-1];
        ctl_ad    = shift_q[SH_W-2];
        ctl_dt    = shift_q[SH_W-3];
        payload   = {shift_q[NIB_W-2:0], din_i};
        cnt_last  = (cnt_q == CNT_W'(LAST));
        frame_end = (state_q == LNK_CMD) && sck_fall_i && cnt_last;
        is_addr   = ctl_ad && !ctl_dt;
        is_write  = ctl_dt && !ctl_rw && !ctl_ad;
        is_read   = ctl_rw && ctl_ad && !ctl_dt;
        bit_sel   = BSEL_W'(LAST - int'(cnt_q));
    end

    assign rd_idx_o = payload;

    // Purpose: link sequencing and edge counting; enable low aborts everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LNK_IDLE;
            cnt_q   <= '0;
        end else if (!en_lvl_i) begin
            state_q <= LNK_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                LNK_IDLE: begin
                    if (en_rise_i) begin
                        state_q <= LNK_CMD;
                        cnt_q   <= '0;
                    end
                end
                LNK_CMD: begin
                    if (sck_fall_i) begin
                        cnt_q <= cnt_last ? '0 : cnt_q + 1'b1;
                        if (cnt_last && is_read) state_q <= LNK_RDOUT;
                    end
                end
                LNK_RDOUT: begin
                    if (sck_rise_i) begin
                        cnt_q <= cnt_last ? '0 : cnt_q + 1'b1;
                        if (cnt_last) state_q <= LNK_TAIL;
                    end
                end
                LNK_TAIL: begin
                    if (sck_rise_i) begin
                        state_q <= LNK_CMD;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= LNK_IDLE;
            endcase
        end
    end

    // Purpose: shift in frame bits on falling edges while a frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  shift_q <= '0;
        else if (sck_fall_i && state_q == LNK_CMD)   shift_q <= {shift_q[SH_W-2:0], din_i};
    end

    // Purpose: address register, loaded only by an address-strobe frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                     addr_q <= '0;
        else if (frame_end && is_addr)  addr_q <= payload;
    end

    // Purpose: one-cycle write request at the end of a data-write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb_o  <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_stb_o  <= frame_end && is_write && en_lvl_i;
            wr_data_o <= payload;
        end
    end

    // Purpose: capture the nibble to be returned when a read frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rd_hold_q <= '0;
        else if (frame_end && is_read)  rd_hold_q <= rd_nib_i;
    end

    // Purpose: drive and release the data line at the defined rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_lvl_i) begin
            doe_o  <= 1'b0;
            dout_o <= 1'b0;
        end else if (sck_rise_i) begin
            if (state_q == LNK_RDOUT) begin
                if (cnt_q == CNT_W'(DRIVE_K)) begin
                    doe_o  <= 1'b1;
                    dout_o <= 1'b0;
                end
                if (cnt_q >= CNT_W'(DATA_K)) dout_o <= rd_hold_q[bit_sel];
            end else if (state_q == LNK_TAIL) begin
                doe_o  <= 1'b0;
                dout_o <= 1'b0;
            end
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/nib3w_slave.sv
`timescale 1ns/1ps
// Module: top of the three-wire nibble register slave. It synchronizes the
// serial pins, finds their edges, and joins the frame engine to the register
// file. Assumes the pad combines sdio_o/sdio_oe into the shared line outside.
module nib3w_slave #(
    parameter int NIB_W = 4,
    localparam int DEPTH = 2 ** NIB_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_en,
    input  logic ser_clk,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe
);

    localparam int           PIN_EN  = 0;
    localparam int           PIN_CLK = 1;
    localparam int           PIN_DAT = 2;
    localparam logic [2:0]   PIN_RST = 3'b001;   // enable settles high in reset

    logic [2:0]       pin_lvl;
    logic             en_lvl, en_rise, en_fall;
    logic             sck_rise, sck_fall;
    logic [NIB_W-1:0] rd_idx, rd_nib, addr_q, wr_data;
    logic             wr_stb;
    logic [DEPTH-1:0] wr_hit;

    nib3w_sync #(.W(3), .RST_VAL(PIN_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdio_i, ser_clk, ser_en}),
        .level_o (pin_lvl)
    );

    assign en_lvl = pin_lvl[PIN_EN];

    nib3w_edge #(.RST_VAL(PIN_RST[PIN_EN])) u_en_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (en_lvl),
        .rise_o  (en_rise),
        .fall_o  (en_fall)
    );

    nib3w_edge #(.RST_VAL(PIN_RST[PIN_CLK])) u_sck_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_lvl[PIN_CLK]),
        .rise_o  (sck_rise),
        .fall_o  (sck_fall)
    );

    nib3w_frame #(.NIB_W(NIB_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_lvl_i   (en_lvl),
        .en_rise_i  (en_rise),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .din_i      (pin_lvl[PIN_DAT]),
        .rd_nib_i   (rd_nib),
        .rd_idx_o   (rd_idx),
        .addr_o     (addr_q),
        .wr_stb_o   (wr_stb),
        .wr_data_o  (wr_data),
        .dout_o     (sdio_o),
        .doe_o      (sdio_oe)
    );

    nib3w_regfile #(.NIB_W(NIB_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb),
        .wr_idx_i  (addr_q),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_nib),
        .wr_hit_o  (wr_hit)
    );

endmodule

// File: rtl/nib3w_checker.sv
`timescale 1ns/1ps
// Module: protocol checker bound into nib3w_slave. It watches line
// turnaround, address movement and write decoding.
module nib3w_checker #(
    parameter int NIB_W = 4,
    localparam int DEPTH = 2 ** NIB_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_fall,
    input logic             en_lvl,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             sdio_o,
    input logic             sdio_oe,
    input logic [NIB_W-1:0] addr_q,
    input logic [DEPTH-1:0] wr_hit
);

    // R2: enable going low releases the line
    a_r2_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !sdio_oe);

    // R6: the line is taken only in response to a shift-clock rising edge
    a_r6_drive_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sck_rise));

    // R8: the line is released only by a rising edge or by disable
    a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe) |-> ($past(sck_rise) || !$past(en_lvl)));

    // R7: a driven bit holds between rising edges
    a_r7_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && $past(sdio_oe) && !$past(sck_rise)) |-> $stable(sdio_o));

    // R4: the address register moves only after a sampling edge
    a_r4_addr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> $past(sck_fall));

    // R10: at most one cell is written at a time
    a_r10_one_cell: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));

endmodule

bind nib3w_slave nib3w_checker #(.NIB_W(NIB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_fall  (en_fall),
    .en_lvl   (en_lvl),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdio_o   (sdio_o),
    .sdio_oe  (sdio_oe),
    .addr_q   (addr_q),
    .wr_hit   (wr_hit)
);

// File: tb/test_nib3w_slave.sv
`timescale 1ns/1ps
// Scoreboard bench. Driver tasks shift frames in and queue the expected read
// nibbles. A monitor rebuilds each nibble from the line and compares it.
module test_nib3w_slave;

    logic clk = 1'b0;
    logic rst_n, ser_en, ser_clk, sdio_i;
    logic sdio_o, sdio_oe;

    always #2 clk = ~clk;   // 250 MHz

    nib3w_slave i_nib3w_slave (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
    );

    typedef struct { logic [3:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One shift-clock pulse: present data, rise, sample oe mid-high, fall.
    task automatic sck_pulse(input logic b, output logic oe_mid);
        sdio_i  = b;
        ser_clk = 1'b1;
        wait_clk(8);
        oe_mid  = sdio_oe;
        wait_clk(2);
        ser_clk = 1'b0;
        wait_clk(10);
    endtask

    // R8: at the first pulse of every frame the line must be released.
    task automatic send_frame(input logic [7:0] f);
        logic oe_m;
        for (int i = 7; i >= 0; i--) begin
            sck_pulse(f[i], oe_m);
            if (i == 7) chk(!oe_m, "R8 line released at frame start", int'(oe_m), 0);
        end
    endtask

    task automatic xfer_on;
        ser_en = 1'b1;
        wait_clk(10);
    endtask

    task automatic xfer_off;
        wait_clk(10);
        ser_en = 1'b0;
        wait_clk(10);
        chk(!sdio_oe, "R2 line released with enable low", int'(sdio_oe), 0);
    endtask

    // Read frame (RW=1, AD=1, DT=0) plus the 8-pulse output group.
    task automatic do_read(input logic [3:0] a, input logic [3:0] e, input logic b7, input string tag);
        logic oe_m;
        exp_t x;
        send_frame({b7, 3'b110, a});
        x.val = e; x.tag = tag;
        exp_q.push_back(x);
        sck_pulse(1'b0, oe_m);
        chk(!oe_m, "R6 line not driven at output edge 1", int'(oe_m), 0);
        sck_pulse(1'b0, oe_m);
        chk(oe_m, "R6 line driven from output edge 2", int'(oe_m), 1);
        for (int k = 3; k <= 8; k++) sck_pulse(1'b0, oe_m);
    endtask

    // Monitor: for each drive episode with a queued expectation, capture edges 5..8.
    initial begin
        forever begin
            logic [3:0] got;
            exp_t x;
            @(posedge sdio_oe);
            if (exp_q.size() == 0) continue;
            repeat (2) @(posedge ser_clk);
            for (int i = 3; i >= 0; i--) begin
                @(posedge ser_clk);
                wait_clk(8);
                got[i] = sdio_o;
            end
            x = exp_q.pop_front();
            chk(got == x.val, x.tag, int'(got), int'(x.val));
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic oe_m;
        rst_n = 1'b0; ser_en = 1'b1; ser_clk = 1'b0; sdio_i = 1'b0;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);
        chk(!sdio_oe, "R1 reset leaves line released", int'(sdio_oe), 0);

        // R9: enable high since reset, no rising edge seen: this write must not land.
        send_frame(8'h1F);
        wait_clk(10);
        ser_en = 1'b0;
        wait_clk(10);

        // R1 / R9: fresh registers read 0, reads chained under one enable.
        xfer_on();
        do_read(4'h0, 4'h0, 1'b0, "R9 frame before enable rise ignored");
        do_read(4'h5, 4'h0, 1'b0, "R1 register reset to zero");
        xfer_off();

        // R5 / R10: load address 3, write A, then sweep every register.
        xfer_on();
        send_frame(8'h23);
        send_frame(8'h1A);
        xfer_off();
        xfer_on();
        for (int a = 0; a < 16; a++)
            do_read(4'(a), (a == 3) ? 4'hA : 4'h0, 1'(a % 2), "R10 only addressed register written");
        xfer_off();

        // R8: write straight after a read under the same enable.
        xfer_on();
        do_read(4'h3, 4'hA, 1'b1, "R7 read MSB first");
        send_frame(8'h15);
        do_read(4'h3, 4'h5, 1'b0, "R8 write after read same enable");
        xfer_off();

        // R4: AD=1 with DT=1 must not move the address (nor write).
        xfer_on();
        send_frame(8'h22);
        send_frame(8'h37);
        send_frame(8'h19);
        do_read(4'h2, 4'h9, 1'b0, "R4 address kept after AD+DT frame");
        do_read(4'h7, 4'h0, 1'b0, "R4 no write at rejected address");
        xfer_off();

        // R5: control values other than write leave register 2 unchanged.
        xfer_on();
        send_frame(8'h22);
        send_frame(8'h5C);
        send_frame(8'h7C);
        send_frame(8'hCC);
        do_read(4'h2, 4'h9, 1'b0, "R5 non-write control values ignored");
        xfer_off();

        // R3: first bit ignored; a write frame with bit 7 set still writes.
        xfer_on();
        send_frame(8'hA2);
        send_frame(8'h9C);
        do_read(4'h2, 4'hC, 1'b1, "R3 leading control bit ignored");
        xfer_off();

        // R2: partial write frame aborted by enable low.
        xfer_on();
        send_frame(8'h24);
        for (int i = 7; i >= 3; i--) sck_pulse(8'h1F >> i, oe_m);
        xfer_off();
        xfer_on();
        do_read(4'h4, 4'h0, 1'b0, "R2 aborted write left register");
        xfer_off();

        // R2: enable dropped while the line is driven.
        xfer_on();
        send_frame(8'h64);
        sck_pulse(1'b0, oe_m);
        sck_pulse(1'b0, oe_m);
        chk(oe_m, "R6 line driven before abort", int'(oe_m), 1);
        ser_en = 1'b0;
        wait_clk(10);
        chk(!sdio_oe, "R2 abort mid-read releases line", int'(sdio_oe), 0);
        wait_clk(10);

        wait_clk(50);
        chk(exp_q.size() == 0, "R7 every queued read observed", exp_q.size(), 0);
        finish_run();
    end

endmodule